// File: doc/BRIEF.md
# Synchronized clamp pulse generator

The block produces three clamp pulses locked to an external line-sync input. The sync input first passes through a two-flop synchronizer. An edge detector then finds its rising and falling edges. An 8-bit counter counts system-clock ticks, either every clock or every second clock. The counter restarts at zero on each sync rise. On each sync fall, the count is stored in a capture register, and the compare value for pulse C is latched at the same time.

Pulse A opens on the sync rise. Pulse B opens on the sync fall, but only while A is still open. A and B both close when the counter equals compare value A. Pulse C opens on the sync fall and closes when the counter reaches the captured count plus the latched compare value C. That sum is formed at 9 bits. A new sync rise closes C early, and it is the only thing that closes C when the sum exceeds 255. Every pulse edge falls on the system-clock grid.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, the counter, the capture register and all three pulse outputs are 0.
- R2: `pulse_a` goes high 3 clock edges after the first edge at which `sync_in` is sampled high. The counter is zero in that same cycle.
- R3: With `presc_sel` = 0 the counter advances on every clock, and `pulse_a` stays high for `cmp_a` + 1 clocks.
- R4: With `presc_sel` = 1 the counter advances on every second clock, with the phase restarted by each sync rise. `pulse_a` then stays high for 2·`cmp_a` + 1 clocks.
- R5: `pulse_b` goes high 3 clock edges after the first edge at which `sync_in` is sampled low, and only if `pulse_a` is high at that point. It falls together with `pulse_a`. With sync high for H clocks and an A width of W, B is W − H clocks wide if H < W and absent if H ≥ W.
- R6: `pulse_c` goes high 3 clock edges after the sync fall is sampled. With `presc_sel` = 0 and a 9-bit sum of capture plus compare C of at most 255, it stays high for `cmp_c` clocks (`cmp_c` ≥ 1), unless a sync rise ends it first.
- R7: A sync rise forces `pulse_c` low 3 clock edges after it is sampled, so C is never wider than the sync low time.
- R8: If the 9-bit sum of capture and compare C is 256 or more, `pulse_c` is ended only by the next sync rise. A sum of exactly 255 still ends it by compare.
- R9: `cmp_c` is sampled at the sync fall. A change of `cmp_c` while `pulse_c` is high does not change that pulse's width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Asynchronous line-sync input |
| presc_sel | input | 1 | 0: count every clock, 1: count every second clock |
| cmp_a | input | 8 | Compare value ending pulses A and B |
| cmp_c | input | 8 | Width of pulse C in counter ticks, added to the capture value |
| pulse_a | output | 1 | Clamp pulse opened by the sync rise |
| pulse_b | output | 1 | Clamp pulse opened by the sync fall while A is open |
| pulse_c | output | 1 | Fixed-width clamp pulse opened by the sync fall |

## Verification
Any fault in the internal state appears within one sync period, as a wrong start cycle or width on one of the pulses.

- A counter that does not restart, or a prescaler phase that is not reset, shifts the fall of A and B.
- A bad capture value, a compare value that is not latched, or a sum that wraps at 8 bits moves the fall of C.
- A wrongly wrapped sum can also turn an overflow case, where only the next rise should close C, into a compare-terminated pulse.
- A wrong B gating condition shows up at the boundary where the sync high time equals the A width.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    // Rising and falling edges of the synchronized sync input
    typedef struct packed {
        logic rise;
        logic fall;
    } sync_edges_t;

    // Counter advance mode
    typedef enum logic {
        TICK_EVERY = 1'b0,
        TICK_HALF  = 1'b1
    } tick_mode_e;

    // The three clamp outputs
    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } clamp_out_t;

    function automatic logic tick_gate(tick_mode_e mode, logic phase);
        return (mode == TICK_EVERY) || phase;
    endfunction

endpackage

// File: rtl/sync_edge.sv
module sync_edge
    import clamp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        async_in,
    output sync_edges_t edges
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= 1'b0;
                end else if (i == 0) begin
                    chain[i] <= async_in;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    always_comb begin
        edges.rise = chain[STAGES-1] & ~prev;
        edges.fall = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/tick_counter.sv
module tick_counter
    import clamp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  sync_edges_t      edges,
    input  tick_mode_e       mode,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap
);
    logic phase;
    logic tick;

    assign tick = tick_gate(mode, phase);

    always_ff @(posedge clk) begin
        if (rst || edges.rise) phase <= 1'b0;
        else                   phase <= ~phase;
    end

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (edges.rise) cnt <= '0;
        else if (tick)       cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)             cap <= '0;
        else if (edges.fall) cap <= cnt;
    end
endmodule

// File: rtl/pulse_ctrl.sv
module pulse_ctrl
    import clamp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  sync_edges_t      edges,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cap,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_c,
    output clamp_out_t       pulses
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cmpc_q;
    logic [SUM_W-1:0] target;
    logic             match_a;
    logic             hit_c;
    logic             pa, pb, pc;

    assign target  = {1'b0, cap} + {1'b0, cmpc_q};
    assign match_a = (cnt == cmp_a);
    assign hit_c   = ({1'b0, cnt} == target);

    always_ff @(posedge clk) begin
        if (rst)             cmpc_q <= '0;
        else if (edges.fall) cmpc_q <= cmp_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pa <= 1'b0;
            pb <= 1'b0;
            pc <= 1'b0;
        end else begin
            if (edges.rise)   pa <= 1'b1;
            else if (match_a) pa <= 1'b0;

            if (edges.rise || match_a) pb <= 1'b0;
            else if (edges.fall && pa) pb <= 1'b1;

            if (edges.rise)      pc <= 1'b0;
            else if (edges.fall) pc <= 1'b1;
            else if (hit_c)      pc <= 1'b0;
        end
    end

    assign pulses = '{a: pa, b: pb, c: pc};

    p_a_start_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(pa) |-> $past(edges.rise));
    p_a_cnt_zero_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(pa) |-> (cnt == '0));
    p_a_end_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(pa) |-> $past(cnt == cmp_a));
    p_b_needs_a_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pb) |-> $past(pa));
    p_c_start_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pc) |-> $past(edges.fall));
    p_c_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(pc) && !$past(edges.rise)) |-> !$past(target[CNT_W]));
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
    import clamp_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    input  logic             presc_sel,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_c,
    output logic             pulse_a,
    output logic             pulse_b,
    output logic             pulse_c
);
    sync_edges_t      edges;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap;
    clamp_out_t       pulses;

    sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (sync_in),
        .edges    (edges)
    );

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .edges (edges),
        .mode  (tick_mode_e'(presc_sel)),
        .cnt   (cnt),
        .cap   (cap)
    );

    pulse_ctrl #(.CNT_W(CNT_W)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .edges  (edges),
        .cnt    (cnt),
        .cap    (cap),
        .cmp_a  (cmp_a),
        .cmp_c  (cmp_c),
        .pulses (pulses)
    );

    assign pulse_a = pulses.a;
    assign pulse_b = pulses.b;
    assign pulse_c = pulses.c;
endmodule

// File: tb/clamp_pulse_gen_tb.sv
module clamp_pulse_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        int    start;
        int    width;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_in = 1'b0;
    logic       presc_sel = 1'b0;
    logic [7:0] cmp_a = '0;
    logic [7:0] cmp_c = '0;
    logic       pulse_a, pulse_b, pulse_c;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t qa[$], qb[$], qc[$];

    clamp_pulse_gen u_dut (
        .clk(clk), .rst(rst), .sync_in(sync_in), .presc_sel(presc_sel),
        .cmp_a(cmp_a), .cmp_c(cmp_c),
        .pulse_a(pulse_a), .pulse_b(pulse_b), .pulse_c(pulse_c)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string what, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, expv);
        end
    endtask

    // Monitor: measure each high run on an output and compare with the queue
    task automatic observe(string name, int s, int e, ref exp_t q[$]);
        exp_t x;
        n_cmp++;
        if (q.size() == 0) begin
            n_bad++;
            $display("FAIL %s unexpected pulse: actual start %0d width %0d expected none",
                     name, s, e - s);
        end else begin
            x = q.pop_front();
            if (x.start != s || x.width != e - s) begin
                n_bad++;
                $display("FAIL %s %s: actual start %0d width %0d expected start %0d width %0d",
                         x.tag, name, s, e - s, x.start, x.width);
            end
        end
    endtask

    logic pa_q = 0, pb_q = 0, pc_q = 0;
    int   sa, sb, sc;
    always @(negedge clk) begin
        if (!rst) begin
            if (pulse_a && !pa_q) sa = cyc;
            if (!pulse_a && pa_q) observe("pulse_a", sa, cyc, qa);
            if (pulse_b && !pb_q) sb = cyc;
            if (!pulse_b && pb_q) observe("pulse_b", sb, cyc, qb);
            if (pulse_c && !pc_q) sc = cyc;
            if (!pulse_c && pc_q) observe("pulse_c", sc, cyc, qc);
            pa_q <= pulse_a;
            pb_q <= pulse_b;
            pc_q <= pulse_c;
        end
    end

    // Driver: one sync period, high for h clocks then low for l clocks.
    // Expected pulses are derived from the requirements.
    task automatic period(int ca, int cc, int h, int l, bit div2,
                          int mid_cc, string ta, string tb, string tc);
        int r, wa, x, wc;
        r = cyc;
        presc_sel = div2;
        cmp_a = 8'(ca);
        cmp_c = 8'(cc);
        sync_in = 1'b1;
        wa = div2 ? 2*ca + 1 : ca + 1;
        qa.push_back('{r + 3, wa, ta});
        if (h < wa) qb.push_back('{r + h + 3, wa - h, tb});
        x  = div2 ? (h - 1) / 2 : h - 1;
        wc = (x + cc > 255 || cc >= l) ? l : cc;
        qc.push_back('{r + h + 3, wc, tc});
        repeat (h) @(negedge clk);
        sync_in = 1'b0;
        for (int i = 0; i < l; i++) begin
            if (i == 5 && mid_cc >= 0) cmp_c = 8'(mid_cc);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pulse_a == 1'b0, "R1 pulse_a in reset", int'(pulse_a), 0);
        check(pulse_b == 1'b0, "R1 pulse_b in reset", int'(pulse_b), 0);
        check(pulse_c == 1'b0, "R1 pulse_c in reset", int'(pulse_c), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R2 R3 R5 R6 R9: mid-pulse change of cmp_c must not alter C
        period(5, 20, 3, 60, 0, 3, "R2 R3", "R5", "R9 R6");
        // R5 boundary: sync high one clock shorter than A
        period(5, 20, 5, 40, 0, -1, "R3", "R5 width 1", "R6");
        // R5 boundary: equal width gives no B; R7 early end of C
        period(5, 40, 6, 15, 0, -1, "R3", "R5", "R7");
        // R8: sum exactly 255 ends by compare
        period(5, 56, 200, 80, 0, -1, "R3", "R5", "R8 sum 255");
        // R8: sum 256 ends only at next rise
        period(5, 57, 200, 80, 0, -1, "R3", "R5", "R8 sum 256");
        // R4: halved counting
        period(20, 255, 9, 60, 1, -1, "R4", "R4 R5", "R8");
        period(1, 255, 10, 20, 1, -1, "R4 min", "R5", "R8 R7");
        period(3, 10, 2, 30, 0, -1, "R3", "R5", "R6");
        repeat (20) @(negedge clk);

        check(qa.size() == 0, "R2 pending pulse_a", qa.size(), 0);
        check(qb.size() == 0, "R5 pending pulse_b", qb.size(), 0);
        check(qc.size() == 0, "R6 pending pulse_c", qc.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R1: actual %0d cycles expected fewer", WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule